// File: doc/BRIEF.md
# Timer Tick Source Front End

This block sits in front of a general-purpose timer counter and decides, on every cycle of the fast internal clock, whether the counter advances. The counter can be advanced on every internal clock cycle, on a chosen edge of an external input pin, on rising edges of an external trigger input, or on each overflow pulse of a neighbouring timer, so that the neighbour acts as a prescaler. External inputs are first brought into the internal clock domain by a flop synchronizer. A one-cycle tick pulse is then derived by comparing the two oldest synchronized samples.

Software holds three control bits through a single configuration write strobe. These are the counter enable, the count direction and an update-generation bit that clears itself. The block drives an up/down counter with an auto-reload limit. It flags every wrap and every software update with a one-cycle update event.

Top module: `tmr_tick_front`

## Requirements
- R1: After reset, `count` is 0, and `update_evt`, `update_gen_bit` and `counter_enabled` are all 0.
- R2: While the latched enable bit is 0, `count` does not change for any tick source or input activity, apart from a software update.
- R3: With `slave_mode` equal to 3'b000, or to any code except 3'b111, and with `trig_mode_en` low, an enabled counter advances on every internal clock cycle.
- R4: With `slave_mode` equal to 3'b111, `trig_mode_en` low and `pin_from_neighbor` low, the counter advances once per rising edge of `pin_in` when `pin_fall_edge` is 0, and once per falling edge when it is 1. A level set on `pin_in` just after a clock edge shows in `count` after the third following rising clock edge.
- R5: With `slave_mode` equal to 3'b111 and `pin_from_neighbor` high, the counter advances once for each cycle in which `neighbor_ovf` is high, and `pin_in` is ignored.
- R6: With `trig_mode_en` high, the counter advances once per rising edge of `trig_in`, whatever `slave_mode` holds, and `pin_in` is ignored.
- R7: Counting up (direction bit 0), the counter goes from the reload value to 0 on the next tick and raises `update_evt` in the cycle in which the 0 appears.
- R8: Counting down (direction bit 1), the counter goes from 0 to the reload value on the next tick and raises `update_evt` in the cycle in which the reload value appears.
- R9: A configuration write with `cfg_update_gen` set makes `update_gen_bit` read 1 for exactly one cycle, after which it returns to 0 by itself.
- R10: A software update loads `count` with 0 when counting up or with `reload` when counting down, and raises `update_evt`. This happens whether or not the counter is enabled.
- R11: `update_evt` is high for a single cycle per isolated event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the three control bits |
| cfg_enable | input | 1 | Counter enable value to write |
| cfg_count_down | input | 1 | Direction value to write (1 = down) |
| cfg_update_gen | input | 1 | Update-generation request (self-clearing) |
| slave_mode | input | 3 | Tick source code: 3'b111 external edge mode, others internal clock |
| trig_mode_en | input | 1 | Selects external trigger counting, overrides slave_mode |
| pin_fall_edge | input | 1 | Active edge of the pin source: 0 rising, 1 falling |
| pin_from_neighbor | input | 1 | In mode 3'b111, count neighbour overflow pulses instead of the pin |
| pin_in | input | 1 | Asynchronous external timer input |
| trig_in | input | 1 | Asynchronous external trigger input |
| neighbor_ovf | input | 1 | Synchronous overflow pulse from another timer |
| reload | input | 16 | Auto-reload limit |
| count | output | 16 | Counter value |
| update_evt | output | 1 | One-cycle update event |
| update_gen_bit | output | 1 | Readback of the self-clearing update bit |
| counter_enabled | output | 1 | Readback of the latched enable bit |

## Verification
Each tick source is driven with the other sources active at the same time: pin toggling during neighbour counting, and pin toggling under the trigger mode. This shows that the selector gives priority to the right source and does not just count any activity. The same pin waveform is counted under both edge polarities. The waveform has one more rise than fall, so an inverted or dual-edge detector is caught. A single pin step, sampled cycle by cycle, pins the synchronizer latency. Long free-running sequences in both directions with a small reload value pin the wrap points and the placement of the update pulses. A separate run with a nonzero, non-111 mode code shows the fallback to internal clocking.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [2:0] SM_INTERNAL = 3'b000;
  localparam logic [2:0] SM_EXT_EDGE = 3'b111;

  typedef enum logic [1:0] {
    SRC_INTERNAL = 2'd0,
    SRC_PIN      = 2'd1,
    SRC_NEIGHBOR = 2'd2,
    SRC_TRIGGER  = 2'd3
  } tick_src_e;

  // Result of one counting step: next value and wrap flag.
  typedef struct packed {
    logic        wrap;
    logic [31:0] value;
  } step_t;

  function automatic step_t count_step(input logic [31:0] cur,
                                       input logic [31:0] lim,
                                       input logic        down);
    step_t r;
    if (!down) begin
      r.wrap  = (cur >= lim);
      r.value = r.wrap ? 32'd0 : cur + 32'd1;
    end else begin
      r.wrap  = (cur == 32'd0);
      r.value = r.wrap ? lim : cur - 32'd1;
    end
    return r;
  endfunction

  function automatic logic [31:0] reinit_value(input logic [31:0] lim,
                                               input logic        down);
    return down ? lim : 32'd0;
  endfunction

endpackage

// File: rtl/tmr_input_sync.sv
module tmr_input_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[LAST-1:0], d_async};
  end

  assign rise = sh[LAST-1] & ~sh[LAST];
  assign fall = ~sh[LAST-1] & sh[LAST];

  // R4: detected edges are single-cycle pulses
  a_r4_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  a_r4_fall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/tmr_tick_select.sv
module tmr_tick_select
  import tmr_pkg::*;
(
  input  logic       enable,
  input  logic [2:0] slave_mode,
  input  logic       trig_mode_en,
  input  logic       pin_fall_edge,
  input  logic       pin_from_neighbor,
  input  logic       pin_rise,
  input  logic       pin_fall,
  input  logic       trig_rise,
  input  logic       neighbor_ovf,
  output tick_src_e  src,
  output logic       tick
);
  logic raw;

  always_comb begin
    if (trig_mode_en)                    src = SRC_TRIGGER;
    else if (slave_mode == SM_EXT_EDGE)  src = pin_from_neighbor ? SRC_NEIGHBOR : SRC_PIN;
    else                                 src = SRC_INTERNAL;

    unique case (src)
      SRC_TRIGGER:  raw = trig_rise;
      SRC_NEIGHBOR: raw = neighbor_ovf;
      SRC_PIN:      raw = pin_fall_edge ? pin_fall : pin_rise;
      default:      raw = 1'b1;
    endcase
  end

  assign tick = enable & raw;
endmodule

// File: rtl/tmr_updown_counter.sv
module tmr_updown_counter
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         dir_down,
  input  logic         reinit,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         upd_evt
);
  step_t       nxt;
  logic [31:0] init_v;

  always_comb begin
    nxt    = count_step(32'(cnt), 32'(reload), dir_down);
    init_v = reinit_value(32'(reload), dir_down);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      upd_evt <= 1'b0;
    end else if (reinit) begin
      cnt     <= init_v[W-1:0];
      upd_evt <= 1'b1;
    end else if (tick) begin
      cnt     <= nxt.value[W-1:0];
      upd_evt <= nxt.wrap;
    end else begin
      upd_evt <= 1'b0;
    end
  end

  // R7: upward wrap lands on zero with an update event
  a_r7_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reinit && !dir_down && cnt == reload) |=> (cnt == '0 && upd_evt));
  // R8: downward wrap lands on reload with an update event
  a_r8_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reinit && dir_down && cnt == '0) |=> (cnt == $past(reload) && upd_evt));
  // R10: software update reinitializes by direction
  a_r10_reinit: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (upd_evt && cnt == ($past(dir_down) ? $past(reload) : '0)));
  // R11: no event without a tick or reinit in the previous cycle
  a_r11_evt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reinit) |=> !upd_evt);
endmodule

// File: rtl/tmr_tick_front.sv
module tmr_tick_front
  import tmr_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic         cfg_enable,
  input  logic         cfg_count_down,
  input  logic         cfg_update_gen,
  input  logic [2:0]   slave_mode,
  input  logic         trig_mode_en,
  input  logic         pin_fall_edge,
  input  logic         pin_from_neighbor,
  input  logic         pin_in,
  input  logic         trig_in,
  input  logic         neighbor_ovf,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         update_evt,
  output logic         update_gen_bit,
  output logic         counter_enabled
);
  localparam int N_EXT = 2;  // index 0: pin, index 1: trigger

  logic en_q, dir_q, ug_q;
  logic [N_EXT-1:0] ext_async, ext_rise, ext_fall;
  tick_src_e src;
  logic      tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      dir_q <= 1'b0;
      ug_q  <= 1'b0;
    end else begin
      ug_q <= cfg_wr & cfg_update_gen;
      if (cfg_wr) begin
        en_q  <= cfg_enable;
        dir_q <= cfg_count_down;
      end
    end
  end

  assign ext_async = {trig_in, pin_in};

  for (genvar g = 0; g < N_EXT; g++) begin : g_sync
    tmr_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(ext_async[g]),
      .rise   (ext_rise[g]),
      .fall   (ext_fall[g])
    );
  end

  tmr_tick_select u_sel (
    .enable           (en_q),
    .slave_mode       (slave_mode),
    .trig_mode_en     (trig_mode_en),
    .pin_fall_edge    (pin_fall_edge),
    .pin_from_neighbor(pin_from_neighbor),
    .pin_rise         (ext_rise[0]),
    .pin_fall         (ext_fall[0]),
    .trig_rise        (ext_rise[1]),
    .neighbor_ovf     (neighbor_ovf),
    .src              (src),
    .tick             (tick)
  );

  tmr_updown_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .dir_down(dir_q),
    .reinit  (ug_q),
    .reload  (reload),
    .cnt     (count),
    .upd_evt (update_evt)
  );

  assign update_gen_bit  = ug_q;
  assign counter_enabled = en_q;

  // R9: the update bit only rises after a software request
  a_r9_ug_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ug_q) |-> $past(cfg_wr && cfg_update_gen));
  // R9: without a new request the bit is gone after one cycle
  a_r9_ug_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ug_q && !(cfg_wr && cfg_update_gen)) |=> !ug_q);
  // R2: disabled counter holds unless updated by software
  a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ug_q) |=> $stable(count));
  // R6: trigger mode never ticks without a trigger edge
  a_r6_trig_only: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode_en && !ext_rise[1]) |-> !tick);
endmodule

// File: tb/tmr_tick_front_tb.sv
module tmr_tick_front_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_enable = 0, cfg_count_down = 0, cfg_update_gen = 0;
  logic [2:0] slave_mode = 3'b000;
  logic trig_mode_en = 0, pin_fall_edge = 0, pin_from_neighbor = 0;
  logic pin_in = 0, trig_in = 0, neighbor_ovf = 0;
  logic [W-1:0] reload = 16'd100;
  logic [W-1:0] count;
  logic update_evt, update_gen_bit, counter_enabled;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_tick_front #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
    .cfg_count_down(cfg_count_down), .cfg_update_gen(cfg_update_gen),
    .slave_mode(slave_mode), .trig_mode_en(trig_mode_en),
    .pin_fall_edge(pin_fall_edge), .pin_from_neighbor(pin_from_neighbor),
    .pin_in(pin_in), .trig_in(trig_in), .neighbor_ovf(neighbor_ovf),
    .reload(reload), .count(count), .update_evt(update_evt),
    .update_gen_bit(update_gen_bit), .counter_enabled(counter_enabled)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Full control write; returns at the negedge after it was latched.
  task automatic write_cfg(input logic en, input logic down, input logic ug);
    @(negedge clk);
    cfg_wr = 1; cfg_enable = en; cfg_count_down = down; cfg_update_gen = ug;
    @(negedge clk);
    cfg_wr = 0; cfg_update_gen = 0;
  endtask

  // Disabled software update, returns once the reinit has landed.
  task automatic soft_update(input logic down);
    write_cfg(0, down, 1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 count", count, 0);
    check("R1 update_evt", update_evt, 0);
    check("R1 update_gen_bit", update_gen_bit, 0);
    check("R1 counter_enabled", counter_enabled, 0);
  endtask

  task automatic t_update_gen();
    reload = 16'd9;
    write_cfg(0, 1, 1);
    check("R9 bit set", update_gen_bit, 1);
    @(negedge clk);
    check("R9 bit cleared", update_gen_bit, 0);
    check("R10 down reinit", count, 9);
    check("R10 event", update_evt, 1);
    @(negedge clk);
    check("R11 single pulse", update_evt, 0);
    write_cfg(0, 0, 1);
    @(negedge clk);
    check("R10 up reinit", count, 0);
    check("R10 up event", update_evt, 1);
  endtask

  task automatic t_up_wrap();
    reload = 16'd4; slave_mode = 3'b000;
    soft_update(0);
    write_cfg(1, 0, 0);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check("R3/R7 up count", count, k % 5);
      check("R7/R11 up event", update_evt, (k % 5 == 0) ? 1 : 0);
    end
    write_cfg(0, 0, 0);
  endtask

  task automatic t_down_wrap();
    reload = 16'd3; slave_mode = 3'b000;
    soft_update(1);
    check("R10 down start", count, 3);
    write_cfg(1, 1, 0);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      check("R8 down count", count, 3 - (k % 4));
      check("R8/R11 down event", update_evt, (k % 4 == 0) ? 1 : 0);
    end
    write_cfg(0, 0, 0);
  endtask

  task automatic t_hold_disabled();
    int snap;
    reload = 16'd100; slave_mode = 3'b000;
    soft_update(0);
    snap = count;
    for (int i = 0; i < 4; i++) begin
      pin_in = ~pin_in; neighbor_ovf = 1; @(negedge clk);
      neighbor_ovf = 0; @(negedge clk);
    end
    pin_in = 0; wait_n(4);
    check("R2 hold when disabled", count, snap);
    check("R2 enable readback", counter_enabled, 0);
  endtask

  task automatic t_other_code();
    reload = 16'd100; slave_mode = 3'b010;
    soft_update(0);
    write_cfg(1, 0, 0);
    wait_n(7);
    check("R3 non-111 code counts clock", count, 7);
    write_cfg(0, 0, 0);
    slave_mode = 3'b000;
  endtask

  task automatic pin_wave();
    for (int i = 0; i < 4; i++) begin
      pin_in = 1; wait_n(3);
      if (i < 3) begin pin_in = 0; wait_n(3); end
    end
    wait_n(4);
  endtask

  task automatic t_pin_edges();
    reload = 16'd100; slave_mode = 3'b111; pin_from_neighbor = 0;
    pin_fall_edge = 0;
    soft_update(0);
    write_cfg(1, 0, 0);
    pin_wave();
    check("R4 rising edges", count, 4);
    write_cfg(0, 0, 0);
    pin_in = 0; wait_n(4);
    pin_fall_edge = 1;
    soft_update(0);
    write_cfg(1, 0, 0);
    pin_wave();
    check("R4 falling edges", count, 3);
    write_cfg(0, 0, 0);
    pin_in = 0; wait_n(4);
    pin_fall_edge = 0;
  endtask

  task automatic t_pin_latency();
    reload = 16'd100; slave_mode = 3'b111; pin_from_neighbor = 0;
    soft_update(0);
    write_cfg(1, 0, 0);
    pin_in = 1;
    wait_n(2);
    check("R4 not yet counted", count, 0);
    @(negedge clk);
    check("R4 counted after sync", count, 1);
    write_cfg(0, 0, 0);
    pin_in = 0; wait_n(4);
  endtask

  task automatic t_neighbor();
    reload = 16'd100; slave_mode = 3'b111; pin_from_neighbor = 1;
    soft_update(0);
    write_cfg(1, 0, 0);
    for (int i = 0; i < 5; i++) begin
      neighbor_ovf = 1; pin_in = ~pin_in; @(negedge clk);
      neighbor_ovf = 0; wait_n(2);
    end
    wait_n(4);
    check("R5 neighbour pulses", count, 5);
    write_cfg(0, 0, 0);
    pin_in = 0; pin_from_neighbor = 0; wait_n(4);
  endtask

  task automatic t_trigger();
    reload = 16'd100; slave_mode = 3'b111; trig_mode_en = 1;
    soft_update(0);
    write_cfg(1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      trig_in = 1; pin_in = 1; wait_n(3);
      trig_in = 0; pin_in = 0; wait_n(2);
      pin_in = 1; @(negedge clk); pin_in = 0;
    end
    wait_n(5);
    check("R6 trigger edges only", count, 3);
    write_cfg(0, 0, 0);
    slave_mode = 3'b000;
    wait_n(2);
    check("R6 held after disable", count, 3);
    trig_mode_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_update_gen();
    t_up_wrap();
    t_down_wrap();
    t_hold_disabled();
    t_other_code();
    t_pin_edges();
    t_pin_latency();
    t_neighbor();
    t_trigger();
    finish_run();
  end
endmodule